// File: doc/BRIEF.md
# Boundary-scan test access port

This block is the 1149.1 test port of a synchronous memory device. A 16-state controller is stepped by TMS on the rising edge of TCK. It shifts a 3-bit instruction and then routes one of three data paths between TDI and TDO: a one-bit bypass stage, a 32-bit identification register or a boundary-scan chain. The chain has a shift stage and a separate update stage. It sits between the device core and its pads. Depending on the active instruction, the pads are driven by the core, by the update stage, or held off (output enable low, which the pad ring turns into high-Z).

The port has no streaming data. Every pin is a plain level signal, sampled or driven on TCK edges, so no valid/ready handshake and no back-pressure rules apply. The boundary chain holds N_IN + 2·N_OUT + N_FIX cells. Cell 0 is nearest TDO and shifts out first:

- cells 0 to N_IN−1 hold the input pins;
- the next N_OUT cells hold the output pin values;
- the next N_OUT cells hold the output enables;
- the top N_FIX cells are not tied to any pin and capture FIX_DEFAULT.

Top module: `tap_bscan`

## Requirements
- R1: Holding `trst_n` low puts the controller into Test-Logic-Reset at once. Five consecutive rising TCK edges with TMS high also reach Test-Logic-Reset, from any state. In both cases IDCODE becomes the active instruction and the pads return to core control.
- R2: In Capture-IR the instruction shift stage loads binary 001, which shifts out LSB first as 1, 0, 0.
- R3: With IDCODE (opcode 001) active, a data scan first captures ID_VALUE and then shifts it out LSB first.
- R4: BYPASS (opcode 111) and the reserved opcodes 100, 101 and 110 select the same one-bit path. It captures 0, so TDO shows 0 followed by TDI delayed by one shift.
- R5: SAMPLE/PRELOAD (opcode 010) captures the pad states into the chain and loads the update stage on the falling edge in Update-DR. The pads stay under core control.
- R6: EXTEST (opcode 000) drives the output pins and enables from the update stage. In Capture-DR the chain captures the pin states, and the unpinned cells capture FIX_DEFAULT.
- R7: `core_in` always follows `pad_in`, under every instruction, including EXTEST.
- R8: SAMPLE-Z (opcode 011) holds every output enable low and places the full boundary chain between TDI and TDO.
- R9: TDO and its enable change on the falling edge of TCK. The enable is high only in Shift-IR and Shift-DR. The active instruction also changes on a falling edge, in Update-IR.
- R10: Cell order is fixed. Bit 0 (nearest TDO) holds `pad_in[0]`, followed by the input pins, then the output values, then the output enables, then the FIX_DEFAULT cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low (tie high if unused) |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, changes on falling TCK |
| tdo_oe | output | 1 | Drive enable for TDO; low means high-Z |
| pad_in | input | N_IN | Device input pins |
| core_in | output | N_IN | Input pin values passed to the core |
| core_out | input | N_OUT | Output data from the core |
| core_oe | input | N_OUT | Output enables from the core |
| pad_out | output | N_OUT | Data to the output pads |
| pad_oe | output | N_OUT | Enables to the output pads |

## Verification
The bench builds the block with two input pins, two output pins and two unpinned cells, which gives an 8-cell chain. At that size, every combination of input pins, core outputs and core enables (64 cases) can be captured and compared bit by bit. All 16 output/enable patterns are preloaded and driven under EXTEST, and every 3-bit opcode can be decoded. The short chain also lets the scans overshift, which shows the path length directly: for the bypass path, the captured 0 and then TDI one shift late; for the boundary chain, the TDI data emerging after eight shifts.

// File: rtl/tap_pkg.sv
package tap_pkg;
  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam int IR_W = 3;
  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPZ  = 3'b011;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [1:0] { DR_BYP, DR_ID, DR_BSR } dr_sel_e;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    case (s)
      ST_TLR:    return m ? ST_TLR    : ST_RTI;
      ST_RTI:    return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: return m ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
      default:   return m ? ST_SEL_DR : ST_RTI;
    endcase
  endfunction

  // Reserved opcodes fall through to the bypass path.
  function automatic dr_sel_e dr_decode(input logic [IR_W-1:0] op);
    case (op)
      OP_IDCODE:                      return DR_ID;
      OP_EXTEST, OP_SAMPLE, OP_SAMPZ: return DR_BSR;
      default:                        return DR_BYP;
    endcase
  endfunction
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_TLR;
    else         state <= tap_next(state, tms);
  end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_sreg,
  output logic [IR_W-1:0] ir_active
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                 ir_sreg <= IR_CAPTURE;
    else if (state == ST_CAP_IR) ir_sreg <= IR_CAPTURE;
    else if (state == ST_SH_IR)  ir_sreg <= {tdi, ir_sreg[IR_W-1:1]};
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)                 ir_active <= OP_IDCODE;
    else if (state == ST_TLR)    ir_active <= OP_IDCODE;
    else if (state == ST_UPD_IR) ir_active <= ir_sreg;
  end
endmodule

// File: rtl/tap_shreg.sv
module tap_shreg #(
  parameter int W = 8
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         cap_en,
  input  logic         sh_en,
  input  logic [W-1:0] cap_val,
  input  logic         tdi,
  output logic [W-1:0] q
);
  logic [W-1:0] shifted;

  generate
    if (W == 1) begin : g_one
      assign shifted = tdi;
    end else begin : g_wide
      assign shifted = {tdi, q[W-1:1]};
    end
  endgenerate

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     q <= '0;
    else if (cap_en) q <= cap_val;
    else if (sh_en)  q <= shifted;
  end
endmodule

// File: rtl/tap_bscan.sv
module tap_bscan
  import tap_pkg::*;
#(
  parameter int              N_IN        = 4,
  parameter int              N_OUT       = 4,
  parameter int              N_FIX       = 2,
  parameter logic [N_FIX-1:0] FIX_DEFAULT = '0,
  parameter logic [31:0]     ID_VALUE    = 32'h0A5C_3A4F
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_oe,
  input  logic [N_IN-1:0]  pad_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_oe,
  output logic [N_OUT-1:0] pad_out,
  output logic [N_OUT-1:0] pad_oe
);
  localparam int BSR_LEN = N_IN + 2 * N_OUT + N_FIX;
  localparam int OUT_LSB = N_IN;
  localparam int OE_LSB  = N_IN + N_OUT;

  tap_state_e        state;
  logic [IR_W-1:0]   ir_sreg, ir_active;
  dr_sel_e           dsel;
  logic              cap_dr, sh_dr;
  logic [0:0]        byp_q;
  logic [31:0]       id_q;
  logic [BSR_LEN-1:0] bsr_q, bsr_upd, bsr_cap;
  logic              drive_bsr, hold_off;
  logic              tdo_next;

  tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(state));

  tap_ir u_ir (
    .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
    .ir_sreg(ir_sreg), .ir_active(ir_active)
  );

  assign dsel   = dr_decode(ir_active);
  assign cap_dr = (state == ST_CAP_DR);
  assign sh_dr  = (state == ST_SH_DR);

  tap_shreg #(.W(1)) u_byp (
    .tck(tck), .trst_n(trst_n),
    .cap_en(cap_dr && dsel == DR_BYP), .sh_en(sh_dr && dsel == DR_BYP),
    .cap_val(1'b0), .tdi(tdi), .q(byp_q)
  );

  tap_shreg #(.W(32)) u_id (
    .tck(tck), .trst_n(trst_n),
    .cap_en(cap_dr && dsel == DR_ID), .sh_en(sh_dr && dsel == DR_ID),
    .cap_val(ID_VALUE), .tdi(tdi), .q(id_q)
  );

  assign bsr_cap = {FIX_DEFAULT, pad_oe, pad_out, pad_in};

  tap_shreg #(.W(BSR_LEN)) u_bsr (
    .tck(tck), .trst_n(trst_n),
    .cap_en(cap_dr && dsel == DR_BSR), .sh_en(sh_dr && dsel == DR_BSR),
    .cap_val(bsr_cap), .tdi(tdi), .q(bsr_q)
  );

  // Update stage: loaded on the falling edge so pads move mid-cycle.
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)                                  bsr_upd <= '0;
    else if (state == ST_UPD_DR && dsel == DR_BSR) bsr_upd <= bsr_q;
  end

  // Input pins always reach the core.
  assign core_in = pad_in;

  assign drive_bsr = (ir_active == OP_EXTEST);
  assign hold_off  = (ir_active == OP_SAMPZ);

  generate
    for (genvar g = 0; g < N_OUT; g++) begin : g_pad
      assign pad_out[g] = drive_bsr ? bsr_upd[OUT_LSB + g] : core_out[g];
      assign pad_oe[g]  = hold_off  ? 1'b0 :
                          drive_bsr ? bsr_upd[OE_LSB + g] : core_oe[g];
    end
  endgenerate

  always_comb begin
    tdo_next = 1'b0;
    if (state == ST_SH_IR) tdo_next = ir_sreg[0];
    else if (state == ST_SH_DR) begin
      case (dsel)
        DR_ID:   tdo_next = id_q[0];
        DR_BSR:  tdo_next = bsr_q[0];
        default: tdo_next = byp_q[0];
      endcase
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_next;
      tdo_oe <= (state == ST_SH_IR) || (state == ST_SH_DR);
    end
  end
endmodule

// File: rtl/tap_bscan_chk.sv
module tap_bscan_chk
  import tap_pkg::*;
#(
  parameter int N_OUT = 4
) (
  input logic            tck,
  input logic            trst_n,
  input logic            tms,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir_sreg,
  input logic [IR_W-1:0] ir_active,
  input logic [N_OUT-1:0] pad_oe,
  input logic            tdo_oe
);
  // R1: five TMS-high edges always land in Test-Logic-Reset
  p_five_ones_r1: assert property (@(posedge tck) disable iff (!trst_n)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
      |=> state == ST_TLR);

  // R1: Test-Logic-Reset restores IDCODE on the next falling edge
  p_tlr_idcode_r1: assert property (@(negedge tck) disable iff (!trst_n)
    state == ST_TLR |=> ir_active == OP_IDCODE);

  // R2: Capture-IR loads the fixed pattern
  p_ir_capture_r2: assert property (@(posedge tck) disable iff (!trst_n)
    state == ST_CAP_IR |=> ir_sreg == IR_CAPTURE);

  // R8: SAMPLE-Z keeps every enable low
  p_samplez_off_r8: assert property (@(posedge tck) disable iff (!trst_n)
    ir_active == OP_SAMPZ |-> pad_oe == '0);

  // R9: TDO drives only while shifting
  p_tdo_oe_r9: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == (state == ST_SH_IR || state == ST_SH_DR));
endmodule

bind tap_bscan tap_bscan_chk #(.N_OUT(N_OUT)) u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .state(state),
  .ir_sreg(ir_sreg), .ir_active(ir_active), .pad_oe(pad_oe), .tdo_oe(tdo_oe)
);

// File: tb/tap_bscan_tb_top.sv
module tap_bscan_tb_top;
  localparam int          N_IN  = 2;
  localparam int          N_OUT = 2;
  localparam int          N_FIX = 2;
  localparam logic [1:0]  FIXV  = 2'b10;
  localparam logic [31:0] IDV   = 32'h1234_5679;
  localparam int          BL    = N_IN + 2 * N_OUT + N_FIX;

  logic tck = 1'b0;
  logic trst_n, tms, tdi;
  logic tdo, tdo_oe;
  logic [N_IN-1:0]  pad_in, core_in;
  logic [N_OUT-1:0] core_out, core_oe, pad_out, pad_oe;
  int tests = 0, fails = 0;
  bit done = 0;
  logic shift_oe_ok;

  always #10 tck = ~tck;

  tap_bscan #(.N_IN(N_IN), .N_OUT(N_OUT), .N_FIX(N_FIX), .FIX_DEFAULT(FIXV),
              .ID_VALUE(IDV)) dut_i (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .pad_in(pad_in), .core_in(core_in), .core_out(core_out), .core_oe(core_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive after the falling edge; TDO seen here leaves on the next rising edge.
  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck);
    #2;
    tms = m;
    tdi = d;
    o = tdo;
    if (tdo_oe !== 1'b1) shift_oe_ok = 1'b0;
  endtask

  task automatic move(input logic m);
    logic o;
    @(negedge tck);
    #2;
    tms = m;
    tdi = 1'b0;
    o = tdo;
  endtask

  task automatic ir_load(input logic [2:0] op, output logic [2:0] cap);
    logic o;
    move(1); move(1); move(0); move(0);
    shift_oe_ok = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step(i == 2, op[i], o);
      cap[i] = o;
    end
    move(1); move(0);
  endtask

  task automatic dr_scan(input int n, input logic [31:0] din, output logic [31:0] dout);
    logic o;
    dout = '0;
    move(1); move(0); move(0);
    shift_oe_ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o);
      dout[i] = o;
    end
    move(1); move(0);
  endtask

  function automatic logic [7:0] bsr_exp(input logic [1:0] pin, input logic [1:0] pout,
                                         input logic [1:0] poe);
    return {FIXV, poe, pout, pin};
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [2:0]  cap;
    logic [31:0] d, din;
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0;
    pad_in = 2'b01; core_out = 2'b10; core_oe = 2'b11;
    #35;
    check("R9 tdo_oe in reset", {31'b0, tdo_oe}, 32'h0);
    check("R1 pads core in reset", {28'b0, pad_oe, pad_out}, {28'b0, core_oe, core_out});
    trst_n = 1'b1;
    move(0);

    // R3: default instruction reads the ID register
    dr_scan(32, 32'h0, d);
    check("R3 idcode after reset", d, IDV);
    check("R9 tdo_oe while shifting", {31'b0, shift_oe_ok}, 32'h1);
    check("R9 tdo_oe in idle", {31'b0, tdo_oe}, 32'h0);

    // R2: capture pattern on every IR load
    ir_load(3'b001, cap);
    check("R2 capture-IR pattern", {29'b0, cap}, 32'h1);

    // R4: bypass and reserved opcodes
    for (int op = 4; op < 8; op++) begin
      ir_load(op[2:0], cap);
      din = 32'h1A5;
      dr_scan(9, din, d);
      check($sformatf("R4 bypass path op=%0d", op), d & 32'h1FF, {23'b0, din[7:0], 1'b0});
    end

    // R5 R10: exhaustive capture sweep under SAMPLE/PRELOAD
    ir_load(3'b010, cap);
    for (int k = 0; k < 64; k++) begin
      pad_in = k[1:0]; core_out = k[3:2]; core_oe = k[5:4];
      din = {16'h0, 8'(k), 8'(k ^ 8'h5A)};
      dr_scan(16, din, d);
      check($sformatf("R10 capture order k=%0d", k), d & 32'hFF,
            {24'b0, bsr_exp(k[1:0], k[3:2], k[5:4])});
      check($sformatf("R5 pads stay core k=%0d", k), {28'b0, pad_oe, pad_out},
            {28'b0, core_oe, core_out});
    end

    // R6 R7: preload then EXTEST, all output/enable patterns
    core_out = 2'b00; core_oe = 2'b00;
    for (int p = 0; p < 16; p++) begin
      logic [7:0] pre;
      pre = {2'b00, p[3:2], p[1:0], 2'b00};
      ir_load(3'b010, cap);
      dr_scan(8, {24'b0, pre}, d);
      ir_load(3'b000, cap);
      check($sformatf("R6 extest drive p=%0d", p), {28'b0, pad_oe, pad_out},
            {28'b0, p[3:2], p[1:0]});
      pad_in = 2'(p + 1);
      #1;
      check($sformatf("R7 core_in follows p=%0d", p), {30'b0, core_in}, {30'b0, pad_in});
      dr_scan(8, {24'b0, pre}, d);
      check($sformatf("R6 extest capture p=%0d", p), d & 32'hFF,
            {24'b0, bsr_exp(pad_in, p[1:0], p[3:2])});
    end

    // R8: SAMPLE-Z
    core_out = 2'b01; core_oe = 2'b11; pad_in = 2'b10;
    ir_load(3'b011, cap);
    check("R8 enables off", {30'b0, pad_oe}, 32'h0);
    din = 32'h0000_C300;
    dr_scan(16, din, d);
    check("R8 full chain path", d & 32'hFFFF, {16'b0, din[7:0], bsr_exp(2'b10, 2'b01, 2'b00)});

    // R1: five TMS-high edges from Shift-DR
    ir_load(3'b010, cap);
    dr_scan(8, 32'h34, d);
    ir_load(3'b000, cap);
    core_out = 2'b10; core_oe = 2'b00;
    #1;
    check("R6 extest before reset", {28'b0, pad_oe, pad_out}, {28'b0, 2'b11, 2'b01});
    move(1); move(0); move(0);
    for (int i = 0; i < 5; i++) move(1);
    move(0);
    check("R1 tms reset pads core", {28'b0, pad_oe, pad_out}, {28'b0, core_oe, core_out});
    dr_scan(32, 32'h0, d);
    check("R1 idcode after tms reset", d, IDV);

    // R1: asynchronous TRST
    ir_load(3'b010, cap);
    dr_scan(8, 32'h34, d);
    ir_load(3'b000, cap);
    check("R6 extest before trst", {30'b0, pad_out}, 32'h1);
    #3;
    trst_n = 1'b0;
    #1;
    check("R1 trst pads core", {28'b0, pad_oe, pad_out}, {28'b0, core_oe, core_out});
    #3;
    trst_n = 1'b1;
    move(0);
    dr_scan(32, 32'h0, d);
    check("R1 idcode after trst", d, IDV);

    done = 1;
    summary();
    $finish;
  end
endmodule